// File: doc/BRIEF.md
# Timed Page Load and Program Controller

This block collects byte loads for one page of a nonvolatile array and then launches the internal program cycle for that page. Each load brings an address and a data byte. The address splits into a page number and a byte index. The first load of a sequence is taken only when the external command-unlock enable is high. That load fixes the page, and every later load of the same sequence must name the same page. Bytes may arrive in any order, and a byte may be loaded again to replace its value.

The load phase has no explicit end command. It closes when no accepted load arrives within an inactivity window that restarts on each accepted load. A data-page build (`SECTOR_MODE = 0`, 16 bytes) also closes at once when its last empty byte is filled. A sector build (`SECTOR_MODE = 1`, 256 bytes) closes only on the timeout. When a sector closes, every byte that was not loaded is set to the erased value 8'hFF before programming.

While the program timer runs, the block reports busy, ignores loads, and presents the last loaded byte with bit 7 inverted as a polling value. The cell array and the unlock command decoder sit outside the block.

The controller has three states:
- `ST_IDLE`: waits for an unlocked load. Transition *open* goes to `ST_LOAD` on that load. Transition *open-full* goes straight to `ST_PROG` if that one load already fills a data page.
- `ST_LOAD`: gathers bytes. Transition *reload* stays in `ST_LOAD` on a matching load and restarts the window. Transition *fill* goes to `ST_PROG` when a data page becomes complete. Transition *expire* goes to `ST_PROG` when the window runs out.
- `ST_PROG`: runs the program timer. Transition *finish* returns to `ST_IDLE` when it ends.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `busy`, `loading`, `page_err`, `byte_valid`, `last_byte` and every byte of `page_bytes` are zero.
- R2: In the idle state, a load strobe with `unlock_en` low is ignored: no byte is stored, no mask bit is set, and no program cycle starts.
- R3: An accepted load stores `ld_data` at its byte index and sets that index's valid bit. The page number is address bits 14..4 and appears on `page_addr`. In sector mode the index is {address bits 18..15, address bits 3..0}. In data-page mode the index is address bits 3..0, and bits 18..15 are don't-care.
- R4: Loads may target indices in any order. Loading an index again replaces its byte and leaves the other valid bits unchanged. Valid bits are only cleared when a new sequence opens.
- R5: The program cycle (busy high) starts on the clock edge exactly `WINDOW_CYC` cycles after the last accepted load, provided no accepted load comes in between. Each accepted load restarts this window.
- R6: In the load state, a load whose page number differs from the captured page is dropped. It stores nothing and does not restart the window, and it sets `page_err`.
- R7: In data-page mode, the load that fills the last empty byte of the page starts the program cycle on that same clock edge, with no wait for the window.
- R8: In sector mode, when the load phase closes, every unloaded byte of `page_bytes` becomes 8'hFF and loaded bytes keep their values. In data-page mode, unloaded bytes keep their previous contents.
- R9: `busy` stays high for exactly `PROG_CYC` cycles. Load strobes during that time change no output.
- R10: While busy, `poll_byte` equals `last_byte` with bit 7 inverted. Otherwise it equals `last_byte`.
- R11: `page_err` is sticky: it stays high through later sequences and program cycles until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlock_en | input | 1 | Command-unlock enable; qualifies the opening load |
| ld_stb | input | 1 | One-cycle byte load strobe |
| ld_addr | input | ADDR_W | Load address (page bits 14..4) |
| ld_data | input | 8 | Load data byte |
| busy | output | 1 | Program cycle in progress |
| loading | output | 1 | Load phase open |
| page_addr | output | PAGE_W | Captured page number |
| page_bytes | output | NBYTES*8 | Buffer contents; byte i at bits 8i+7..8i |
| byte_valid | output | NBYTES | Per-byte loaded mask |
| last_byte | output | 8 | Data of the last accepted load |
| poll_byte | output | 8 | Polling view of the last byte |
| page_err | output | 1 | Sticky page-mismatch flag |

## Verification
The bench places the window expiry on its exact edge, with one cycle of margin on either side. A timer that is off by one would raise `busy` a cycle early or late. A dropped mismatched load that wrongly restarted the window would delay the start.

The bench also targets three failure modes:
- a mismatched page that overwrites a stored byte;
- a load during busy that moves `last_byte`;
- a sector that leaves unloaded bytes stale instead of erased.

In data-page mode, a design that waited for the timeout after the sixteenth byte would show `busy` low where it must be high. A design that ignored the upper address bits in sector mode would store bytes at the wrong index.

// File: rtl/page_load_pkg.sv
package page_load_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ld_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/page_addr_map.sv
module page_addr_map #(
    parameter int SECTOR_MODE = 1,
    parameter int ADDR_W      = 19,
    parameter int PAGE_LSB    = 4,
    parameter int PAGE_W      = 11,
    parameter int IDX_W       = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [PAGE_W-1:0] page
);
    localparam int HI_LSB = PAGE_LSB + PAGE_W;

    assign page = addr[HI_LSB-1:PAGE_LSB];

    generate
        if (SECTOR_MODE != 0) begin : g_sector
            // Upper bits extend the byte index above the page field.
            assign idx = {addr[ADDR_W-1:HI_LSB], addr[PAGE_LSB-1:0]};
        end else begin : g_page
            assign idx = addr[PAGE_LSB-1:0];
        end
    endgenerate
endmodule

// File: rtl/page_cycle_timer.sv
module page_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (run)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    // R5: the window count never passes its limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/page_byte_buffer.sv
module page_byte_buffer
    import page_load_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int NBYTES      = 256,
    parameter int FILL_ERASED = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open_seq,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic [7:0]          wdata,
    input  logic                seal,
    output logic [NBYTES*8-1:0] bytes_flat,
    output logic [NBYTES-1:0]   valid
);
    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_byte
            logic hit;
            assign hit = we && (widx == IDX_W'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bytes_flat[g*8 +: 8] <= 8'h00;
                end else if (hit) begin
                    bytes_flat[g*8 +: 8] <= wdata;
                end else if (FILL_ERASED != 0 && seal && !valid[g]) begin
                    bytes_flat[g*8 +: 8] <= ERASED_BYTE;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        valid[g] <= 1'b0;
                else if (open_seq) valid[g] <= hit;
                else if (hit)      valid[g] <= 1'b1;
            end
        end
    endgenerate

    // R4: within a sequence the mask only gains bits
    p_mask_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !open_seq |=> ((valid & $past(valid)) == $past(valid)));
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
    import page_load_pkg::*;
#(
    parameter int SECTOR_MODE = 1,
    parameter int WINDOW_CYC  = 7500,
    parameter int PROG_CYC    = 500000,
    parameter int ADDR_W      = 19,
    parameter int PAGE_LSB    = 4,
    parameter int PAGE_W      = 11,
    // derived; leave at default
    parameter int IDX_W  = (SECTOR_MODE != 0) ? (ADDR_W - PAGE_W) : PAGE_LSB,
    parameter int NBYTES = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                unlock_en,
    input  logic                ld_stb,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [7:0]          ld_data,
    output logic                busy,
    output logic                loading,
    output logic [PAGE_W-1:0]   page_addr,
    output logic [NBYTES*8-1:0] page_bytes,
    output logic [NBYTES-1:0]   byte_valid,
    output logic [7:0]          last_byte,
    output logic [7:0]          poll_byte,
    output logic                page_err
);
    ld_state_e state, nxt;

    logic [IDX_W-1:0]  in_idx;
    logic [PAGE_W-1:0] in_page;
    logic              page_match, accept, mismatch, open_seq;
    logic              fills_page, win_done, prog_done, seal;
    logic [NBYTES-1:0] mask_after;

    page_addr_map #(
        .SECTOR_MODE(SECTOR_MODE), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB),
        .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_map (
        .addr(ld_addr), .idx(in_idx), .page(in_page)
    );

    assign page_match = (in_page == page_addr);
    assign accept     = ld_stb && (((state == ST_IDLE) && unlock_en) ||
                                   ((state == ST_LOAD) && page_match));
    assign mismatch   = ld_stb && (state == ST_LOAD) && !page_match;
    assign open_seq   = accept && (state == ST_IDLE);

    always_comb begin
        mask_after = open_seq ? '0 : byte_valid;
        mask_after[in_idx] = 1'b1;
    end
    assign fills_page = (SECTOR_MODE == 0) && accept && (&mask_after);

    page_cycle_timer #(.LIMIT(WINDOW_CYC)) u_window (
        .clk(clk), .rst_n(rst_n),
        .clr(accept || (state != ST_LOAD)),
        .run(state == ST_LOAD),
        .done(win_done)
    );

    page_cycle_timer #(.LIMIT(PROG_CYC)) u_prog (
        .clk(clk), .rst_n(rst_n),
        .clr(state != ST_PROG),
        .run(state == ST_PROG),
        .done(prog_done)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)         nxt = fills_page ? ST_PROG : ST_LOAD;
            ST_LOAD: if (fills_page)     nxt = ST_PROG;
                     else if (accept)    nxt = ST_LOAD;
                     else if (win_done)  nxt = ST_PROG;
            ST_PROG: if (prog_done)      nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    assign seal = (state == ST_LOAD) && (nxt == ST_PROG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // captured page, last byte, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_addr <= '0;
            last_byte <= 8'h00;
            page_err  <= 1'b0;
        end else begin
            if (open_seq) page_addr <= in_page;
            if (accept)   last_byte <= ld_data;
            if (mismatch) page_err  <= 1'b1;
        end
    end

    page_byte_buffer #(
        .IDX_W(IDX_W), .NBYTES(NBYTES), .FILL_ERASED(SECTOR_MODE)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .open_seq(open_seq),
        .we(accept), .widx(in_idx), .wdata(ld_data), .seal(seal),
        .bytes_flat(page_bytes), .valid(byte_valid)
    );

    // outputs from state
    always_comb begin
        busy      = 1'b0;
        loading   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOAD: loading = 1'b1;
            ST_PROG: busy    = 1'b1;
            default: ;
        endcase
        poll_byte = busy ? {~last_byte[7], last_byte[6:0]} : last_byte;
    end

    // R2: an idle load without unlock leaves the block idle
    p_locked_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ld_stb && !unlock_en) |=> (state == ST_IDLE));

    // R6: a foreign-page load changes no stored byte and flags the error
    p_drop_foreign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> ($stable(page_bytes) && page_err));

    // R9: nothing visible moves on a load during the program cycle
    p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_stb) |=> ($stable(byte_valid) && $stable(last_byte)));

    // R11: the error flag never clears without reset
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);
endmodule

// File: tb/test_page_load_ctrl.sv
`timescale 1ns/1ps
module test_page_load_ctrl;
    localparam int W  = 20;
    localparam int PC = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic unlock_en = 1'b0;
    logic stb_s = 1'b0, stb_d = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  data = '0;

    logic s_busy, s_loading, s_err, d_busy, d_loading, d_err;
    logic [10:0] s_page, d_page;
    logic [2047:0] s_bytes;
    logic [127:0]  d_bytes;
    logic [255:0]  s_valid;
    logic [15:0]   d_valid;
    logic [7:0] s_last, s_poll, d_last, d_poll;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    page_load_ctrl #(.SECTOR_MODE(1), .WINDOW_CYC(W), .PROG_CYC(PC)) i_page_load_ctrl (
        .clk(clk), .rst_n(rst_n), .unlock_en(unlock_en), .ld_stb(stb_s),
        .ld_addr(addr), .ld_data(data), .busy(s_busy), .loading(s_loading),
        .page_addr(s_page), .page_bytes(s_bytes), .byte_valid(s_valid),
        .last_byte(s_last), .poll_byte(s_poll), .page_err(s_err));

    page_load_ctrl #(.SECTOR_MODE(0), .WINDOW_CYC(W), .PROG_CYC(PC)) i_page_load_ctrl_d (
        .clk(clk), .rst_n(rst_n), .unlock_en(unlock_en), .ld_stb(stb_d),
        .ld_addr(addr), .ld_data(data), .busy(d_busy), .loading(d_loading),
        .page_addr(d_page), .page_bytes(d_bytes), .byte_valid(d_valid),
        .last_byte(d_last), .poll_byte(d_poll), .page_err(d_err));

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // call at a negedge; strobe is seen at the next posedge
    task automatic load(input logic sector, input logic [18:0] a, input logic [7:0] d);
        addr = a; data = d;
        if (sector) stb_s = 1'b1; else stb_d = 1'b1;
        @(negedge clk);
        stb_s = 1'b0; stb_d = 1'b0;
    endtask

    // {addr, data, expected index}, sector page 0x155
    localparam logic [34:0] VEC [5] = '{
        {19'h01550, 8'hA5, 8'h00},
        {19'h09555, 8'h3C, 8'h15},
        {19'h7955F, 8'hC3, 8'hFF},
        {19'h01553, 8'h3C, 8'h03},
        {19'h01553, 8'h77, 8'h03}
    };

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(s_busy == 0 && s_loading == 0 && s_err == 0 && s_valid == '0 &&
              s_last == 0 && s_bytes == '0, "R1", s_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 locked load ignored
        load(1, 19'h01551, 8'h5A);
        repeat (W + 2) @(negedge clk);
        check(s_valid == '0 && s_busy == 0 && s_loading == 0, "R2", s_valid, 0);

        // R3/R4 vector walk
        unlock_en = 1'b1;
        foreach (VEC[i]) begin
            load(1, VEC[i][34:16], VEC[i][15:8]);
            check(s_bytes[VEC[i][7:0]*8 +: 8] == VEC[i][15:8], "R3",
                  s_bytes[VEC[i][7:0]*8 +: 8], VEC[i][15:8]);
            check(s_page == 11'h155 && s_last == VEC[i][15:8], "R3", s_page, 11'h155);
        end
        check($countones(s_valid) == 4 && s_valid[8'h03] && s_valid[8'h15], "R4",
              $countones(s_valid), 4);

        // R6 foreign page dropped
        load(1, 19'h01563, 8'h11);
        check(s_err == 1 && s_bytes[3*8 +: 8] == 8'h77 && $countones(s_valid) == 4,
              "R6", s_bytes[3*8 +: 8], 8'h77);

        // R5 window from last accepted load, not restarted by the drop
        repeat (W - 2) @(negedge clk);
        check(s_busy == 0, "R5", s_busy, 0);
        @(negedge clk);
        check(s_busy == 1, "R5", s_busy, 1);

        // R8 sector erase fill
        check(s_bytes[8'h10*8 +: 8] == 8'hFF && s_bytes[8'h15*8 +: 8] == 8'h3C,
              "R8", s_bytes[8'h10*8 +: 8], 8'hFF);
        // R10 polling view
        check(s_poll == 8'hF7, "R10", s_poll, 8'hF7);
        // R9 load during busy ignored
        load(1, 19'h01554, 8'h99);
        check(s_last == 8'h77 && !s_valid[4] && s_bytes[4*8 +: 8] == 8'hFF,
              "R9", s_last, 8'h77);
        n = 1;
        while (s_busy) begin n++; @(negedge clk); end
        check(n == PC, "R9", n, PC);
        check(s_poll == 8'h77, "R10", s_poll, 8'h77);

        // R11 error survives a new sequence
        load(1, 19'h02220, 8'h01);
        check(s_err == 1 && s_loading == 1 && s_valid == 256'h1, "R11", s_err, 1);

        // data-page mode: R3 index ignores upper bits, R8 no fill
        load(0, 19'h78AA2, 8'h42);
        load(0, 19'h00AA5, 8'h55);
        check(d_page == 11'h0AA && d_bytes[2*8 +: 8] == 8'h42, "R3", d_bytes[2*8 +: 8], 8'h42);
        repeat (W - 1) @(negedge clk);
        check(d_busy == 0, "R5", d_busy, 0);
        @(negedge clk);
        check(d_busy == 1 && d_valid == 16'h0024, "R5", d_valid, 16'h0024);
        check(d_bytes[0 +: 8] == 8'h00, "R8", d_bytes[0 +: 8], 0);
        while (d_busy) @(negedge clk);

        // R7 full page starts at once
        for (int k = 0; k < 16; k++) begin
            load(0, {4'h0, 11'h0AA, 4'(k)}, 8'(8'h10 + k));
            if (k == 14) check(d_busy == 0, "R7", d_busy, 0);
        end
        check(d_busy == 1 && d_valid == 16'hFFFF && d_bytes[15*8 +: 8] == 8'h1F,
              "R7", d_valid, 16'hFFFF);
        check(d_err == 0, "R11", d_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule